// File: doc/BRIEF.md
# Dual-Line Serial Byte Link with XOR-Interleaved Redundancy

This block sends each byte over two asynchronous serial lines at once and receives bytes from two such lines. The primary line carries the byte unchanged. The redundant line carries a recoded copy in which every bit is the XOR of a data bit and the data bit three places further on, counting cyclically. Both lines use 8N1 framing with the least significant bit first. Both transmitters start in the same clock cycle and use a shared oversampling tick, so the two frames stay aligned.

On the receive side, each line has its own receiver. A receiver takes three samples around the centre of every bit and keeps the majority value, so a short spike on the line has no effect. A resolver pairs the frames from the two lines in order of arrival. It checks the pair against the XOR recoding. If one frame has a bad stop bit, the resolver takes the byte from the other line, or rebuilds it from that line. It then gives the byte with a recovered flag, or raises an uncorrectable flag and gives no byte. A frame that finds no partner within two frame times is resolved on its own.

The caller presents a byte with a valid/ready handshake. It reads resolved bytes from a one-cycle valid pulse that comes with two flags.

Top module: `dual_xor_link`

## Requirements
- R1: On an accepted byte d, the primary line sends d. The redundant line sends r, where r[i] = d[i] XOR d[(i+3) mod 8]. Each frame is one low start bit, eight data bits with bit 0 first, and one high stop bit. Each bit lasts 16 ticks of CLK_DIV clocks.
- R2: in_ready is high only when both transmitters are idle. A byte is taken in the cycle where in_valid and in_ready are both high, and in_ready is low in the cycle after that.
- R3: Each receiver takes three line samples around the bit centre and uses their 2-of-3 majority. A spike of two clock cycles inside a data bit does not change the decoded byte.
- R4: If both frames have a good stop bit and r equals the recoding of the primary byte, out_valid pulses for one cycle with the primary byte. out_recovered and out_uncorrectable stay low.
- R5: If both frames have a good stop bit but r does not match the recoding of the primary byte, out_uncorrectable pulses and out_valid stays low.
- R6: If the primary frame has a bad stop bit and the redundant frame is good, the byte is rebuilt from r. Bit 0 of the received primary byte fixes the solution. out_valid and out_recovered then pulse together.
- R7: If the redundant frame has a bad stop bit and the primary frame is good, the primary byte is given with out_valid and out_recovered.
- R8: A frame left unpaired for 2 × 10 × 16 × CLK_DIV clocks is resolved alone. A good primary frame gives out_valid with out_recovered. A redundant frame alone, or a bad primary frame alone, gives out_uncorrectable.
- R9: If both frames have a bad stop bit, the block gives out_uncorrectable and no out_valid.
- R10: After reset, both TX lines are high, in_ready is high and every output pulse is low. out_valid and out_uncorrectable never occur in the same cycle.
- R11: A low spike of two clock cycles on an idle RX line fails the start-bit majority, so no frame is produced. The next real frame is still decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Both transmitters idle |
| tx_pri | output | 1 | Primary serial output (raw byte) |
| tx_red | output | 1 | Redundant serial output (recoded byte) |
| rx_pri | input | 1 | Primary serial input |
| rx_red | input | 1 | Redundant serial input |
| out_data | output | 8 | Resolved byte |
| out_valid | output | 1 | One-cycle pulse, out_data is good |
| out_recovered | output | 1 | Pulses with out_valid when only one line was used |
| out_uncorrectable | output | 1 | One-cycle pulse, the pair could not be resolved |

## Verification
The assertions assume that in_valid and in_data are driven synchronously. They also assume that a new frame on a line does not start before the previous frame on the same line has been resolved, so that no more than one result is pending at a time. The stimulus keeps to this. It drives each pair of frames, waits for the result pulse or the end of a window of more than three frame times, and only then starts the next pair. The RX lines are driven either directly by bench tasks at the exact bit period or by looping back the TX lines. Spikes are placed well inside a bit, away from its edges.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int BYTE_W     = 8;
    localparam int OVS        = 16;
    localparam int FRAME_BITS = 10;
    localparam int MIX_SHIFT  = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              ok;
    } rx_frame_t;

    typedef struct packed {
        logic              valid;
        logic              rec;
        logic              unc;
        logic [BYTE_W-1:0] data;
    } verdict_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic [BYTE_W-1:0] xor_encode(input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = d[i] ^ d[(i + MIX_SHIFT) % BYTE_W];
        end
        return r;
    endfunction

    // The XOR chain visits every bit because MIX_SHIFT and BYTE_W are coprime.
    function automatic logic [BYTE_W-1:0] xor_decode(input logic [BYTE_W-1:0] r,
                                                     input logic anchor);
        logic [BYTE_W-1:0] d;
        int idx;
        int nxt;
        d    = '0;
        d[0] = anchor;
        idx  = 0;
        for (int j = 0; j < BYTE_W - 1; j++) begin
            nxt    = (idx + MIX_SHIFT) % BYTE_W;
            d[nxt] = r[idx] ^ d[idx];
            idx    = nxt;
        end
        return d;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/dxl_tick.sv
module dxl_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/dxl_tx.sv
module dxl_tx
    import dxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] data,
    output logic              busy,
    output logic              line
);
    localparam int SW = FRAME_BITS;
    localparam int BW = $clog2(FRAME_BITS);

    logic [SW-1:0] shreg;
    logic [3:0]    sub;
    logic [BW-1:0] bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            sub   <= '0;
            bitn  <= '0;
            busy  <= 1'b0;
        end else if (load && !busy) begin
            shreg <= {1'b1, data, 1'b0};
            sub   <= '0;
            bitn  <= '0;
            busy  <= 1'b1;
        end else if (busy && tick) begin
            if (sub == 4'(OVS - 1)) begin
                sub <= '0;
                if (bitn == BW'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[SW-1:1]};
                    bitn  <= bitn + 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/dxl_rx.sv
module dxl_rx
    import dxl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    output logic      done,
    output rx_frame_t frame
);
    logic [1:0]        sync;
    logic              ln;
    rx_state_e         state;
    logic [3:0]        sub;
    logic [2:0]        bitn;
    logic              s0, s1;
    logic              vote;
    logic [BYTE_W-1:0] shreg;

    assign ln   = sync[1];
    assign vote = maj3(s0, s1, ln);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            state <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            s0    <= 1'b1;
            s1    <= 1'b1;
            shreg <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            sync <= {sync[0], line};
            done <= 1'b0;
            if (state == RX_IDLE) begin
                if (!ln) begin
                    state <= RX_START;
                    sub   <= '0;
                    bitn  <= '0;
                end
            end else if (tick) begin
                sub <= sub + 1'b1;
                if (sub == 4'd7) s0 <= ln;
                if (sub == 4'd8) s1 <= ln;
                if (sub == 4'd9) begin
                    unique case (state)
                        RX_START: if (vote) state <= RX_IDLE;
                        RX_DATA:  shreg <= {vote, shreg[BYTE_W-1:1]};
                        RX_STOP: begin
                            done       <= 1'b1;
                            frame.data <= shreg;
                            frame.ok   <= vote;
                            state      <= RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
                if (sub == 4'(OVS - 1)) begin
                    if (state == RX_START) begin
                        state <= RX_DATA;
                    end else if (state == RX_DATA) begin
                        if (bitn == 3'(BYTE_W - 1)) state <= RX_STOP;
                        else                        bitn  <= bitn + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dxl_resolve.sv
module dxl_resolve
    import dxl_pkg::*;
#(
    parameter int TIMEOUT = 1280
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p_done,
    input  rx_frame_t         p_frame,
    input  logic              r_done,
    input  rx_frame_t         r_frame,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_rec,
    output logic              out_unc
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic          pp, rp;
    rx_frame_t     pf, rf;
    logic [TW-1:0] cnt;
    logic          both, lone, expired, fire;
    verdict_t      v;

    assign both    = pp && rp;
    assign lone    = pp ^ rp;
    assign expired = lone && (cnt == TW'(TIMEOUT - 1));
    assign fire    = both || expired;

    always_comb begin
        v = '0;
        if (both) begin
            if (pf.ok && rf.ok) begin
                if (xor_encode(pf.data) == rf.data) begin
                    v.valid = 1'b1;
                    v.data  = pf.data;
                end else begin
                    v.unc = 1'b1;
                end
            end else if (pf.ok) begin
                v.valid = 1'b1;
                v.rec   = 1'b1;
                v.data  = pf.data;
            end else if (rf.ok) begin
                v.valid = 1'b1;
                v.rec   = 1'b1;
                v.data  = xor_decode(rf.data, pf.data[0]);
            end else begin
                v.unc = 1'b1;
            end
        end else if (pp) begin
            if (pf.ok) begin
                v.valid = 1'b1;
                v.rec   = 1'b1;
                v.data  = pf.data;
            end else begin
                v.unc = 1'b1;
            end
        end else begin
            v.unc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pp        <= 1'b0;
            rp        <= 1'b0;
            pf        <= '0;
            rf        <= '0;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_rec   <= 1'b0;
            out_unc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_rec   <= 1'b0;
            out_unc   <= 1'b0;
            if (lone && !expired) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
            if (fire) begin
                out_valid <= v.valid;
                out_rec   <= v.rec;
                out_unc   <= v.unc;
                out_data  <= v.data;
                pp        <= 1'b0;
                rp        <= 1'b0;
            end
            if (p_done) begin
                pp <= 1'b1;
                pf <= p_frame;
            end
            if (r_done) begin
                rp <= 1'b1;
                rf <= r_frame;
            end
        end
    end
endmodule

// File: rtl/dual_xor_link.sv
module dual_xor_link
    import dxl_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       tx_pri,
    output logic       tx_red,
    input  logic       rx_pri,
    input  logic       rx_red,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_recovered,
    output logic       out_uncorrectable
);
    localparam int PAIR_WAIT = 2 * FRAME_BITS * OVS * CLK_DIV;

    logic      tick;
    logic      busy_p, busy_r, load;
    logic      done_p, done_r;
    rx_frame_t frm_p, frm_r;

    assign in_ready = !busy_p && !busy_r;
    assign load     = in_valid && in_ready;

    dxl_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    dxl_tx u_tx_pri (
        .clk(clk), .rst(rst), .tick(tick), .load(load),
        .data(in_data), .busy(busy_p), .line(tx_pri)
    );

    dxl_tx u_tx_red (
        .clk(clk), .rst(rst), .tick(tick), .load(load),
        .data(xor_encode(in_data)), .busy(busy_r), .line(tx_red)
    );

    dxl_rx u_rx_pri (
        .clk(clk), .rst(rst), .tick(tick), .line(rx_pri),
        .done(done_p), .frame(frm_p)
    );

    dxl_rx u_rx_red (
        .clk(clk), .rst(rst), .tick(tick), .line(rx_red),
        .done(done_r), .frame(frm_r)
    );

    dxl_resolve #(.TIMEOUT(PAIR_WAIT)) u_resolve (
        .clk(clk), .rst(rst),
        .p_done(done_p), .p_frame(frm_p),
        .r_done(done_r), .r_frame(frm_r),
        .out_valid(out_valid), .out_data(out_data),
        .out_rec(out_recovered), .out_unc(out_uncorrectable)
    );
endmodule

// File: rtl/dxl_link_checks.sv
module dxl_link_checks (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic tx_pri,
    input logic tx_red,
    input logic out_valid,
    input logic out_recovered,
    input logic out_uncorrectable
);
    p_idle_lines_high_r10: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (tx_pri && tx_red));

    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_valid_not_unc_r10: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_uncorrectable));

    p_rec_has_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_recovered |-> out_valid);

    p_valid_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_unc_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        out_uncorrectable |=> !out_uncorrectable);
endmodule

bind dual_xor_link dxl_link_checks u_link_checks (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .tx_pri(tx_pri), .tx_red(tx_red), .out_valid(out_valid),
    .out_recovered(out_recovered), .out_uncorrectable(out_uncorrectable)
);

// File: tb/dual_xor_link_test.sv
module dual_xor_link_test;
    localparam int CLK_DIV = 4;
    localparam int BITCLK  = 16 * CLK_DIV;
    localparam int NV      = 10;

    // channel modes: 0 good, 1 bad stop, 2 absent, 3 spike in a data bit, 4 wrong byte
    // expected kinds: 0 plain valid, 1 valid+recovered, 2 uncorrectable
    localparam logic [7:0] V_DATA [NV] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h5A,
                                           8'hC3, 8'h81, 8'h7E, 8'h96, 8'h12};
    localparam logic [2:0] V_PM [NV] = '{3'd0, 3'd3, 3'd0, 3'd0, 3'd1,
                                         3'd0, 3'd2, 3'd1, 3'd0, 3'd1};
    localparam logic [2:0] V_RM [NV] = '{3'd0, 3'd0, 3'd3, 3'd1, 3'd0,
                                         3'd2, 3'd0, 3'd1, 3'd4, 3'd2};
    localparam logic [1:0] V_EXP [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
                                          2'd1, 2'd2, 2'd2, 2'd2, 2'd2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, tx_pri, tx_red;
    logic       drv_p = 1'b1, drv_r = 1'b1, loopback = 1'b0;
    logic       rx_pri, rx_red;
    logic [7:0] out_data;
    logic       out_valid, out_recovered, out_uncorrectable;

    int  checks = 0;
    int  fails  = 0;
    bit  ended  = 1'b0;

    logic       g_v, g_r, g_u;
    logic [7:0] g_d;
    logic [7:0] cap_red;

    always #2 clk = ~clk;

    assign rx_pri = loopback ? tx_pri : drv_p;
    assign rx_red = loopback ? tx_red : drv_r;

    dual_xor_link #(.CLK_DIV(CLK_DIV)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tx_pri(tx_pri), .tx_red(tx_red),
        .rx_pri(rx_pri), .rx_red(rx_red), .out_data(out_data),
        .out_valid(out_valid), .out_recovered(out_recovered),
        .out_uncorrectable(out_uncorrectable)
    );

    function automatic logic [7:0] mix(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[i] ^ d[(i + 3) % 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_line(input bit ch, input logic v);
        if (ch) drv_r = v;
        else    drv_p = v;
    endtask

    task automatic send(input bit ch, input logic [7:0] b, input logic [2:0] mode);
        logic [9:0] fr;
        if (mode == 3'd2) return;
        fr = {(mode == 3'd1) ? 1'b0 : 1'b1, b, 1'b0};
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            set_line(ch, fr[k]);
            if (mode == 3'd3 && k == 2) begin
                repeat (31) @(negedge clk);
                set_line(ch, ~fr[k]);
                repeat (2) @(negedge clk);
                set_line(ch, fr[k]);
                repeat (BITCLK - 34) @(negedge clk);
            end else begin
                repeat (BITCLK - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        set_line(ch, 1'b1);
    endtask

    task automatic await(input int maxcyc);
        g_v = 0; g_r = 0; g_u = 0; g_d = '0;
        for (int c = 0; c < maxcyc; c++) begin
            @(negedge clk);
            if (out_valid || out_uncorrectable) begin
                g_v = out_valid; g_r = out_recovered;
                g_u = out_uncorrectable; g_d = out_data;
                return;
            end
        end
    endtask

    task automatic grab_red();
        while (tx_red !== 1'b0) @(negedge clk);
        repeat (BITCLK / 2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            repeat (BITCLK) @(negedge clk);
            cap_red[k] = tx_red;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 tx_pri idle", tx_pri, 1);
        check("R10 tx_red idle", tx_red, 1);
        check("R10 in_ready", in_ready, 1);
        check("R10 outputs quiet", {out_valid, out_recovered, out_uncorrectable}, 0);

        // table of paired-frame vectors
        for (int n = 0; n < NV; n++) begin
            logic [7:0] rb;
            rb = (V_RM[n] == 3'd4) ? mix(V_DATA[n] ^ 8'h10) : mix(V_DATA[n]);
            fork
                send(1'b0, V_DATA[n], V_PM[n]);
                send(1'b1, rb, V_RM[n] == 3'd4 ? 3'd0 : V_RM[n]);
                await(3000);
            join
            if (V_EXP[n] == 2'd2) begin
                // R5 R8 R9: no byte, error flag
                check($sformatf("R5/R8/R9 vec%0d unc", n), {g_v, g_u}, 2'b01);
            end else begin
                // R3 R4 R6 R7 R8: byte delivered
                check($sformatf("R4/R6/R7 vec%0d data", n), g_d, V_DATA[n]);
                check($sformatf("R4/R6/R7 vec%0d flags", n), {g_v, g_r, g_u},
                      {1'b1, V_EXP[n] == 2'd1, 1'b0});
            end
            repeat (200) @(negedge clk);
        end

        // R11: spike on idle lines is no frame
        @(negedge clk); drv_p = 0; drv_r = 0;
        repeat (2) @(negedge clk); drv_p = 1; drv_r = 1;
        await(3000);
        check("R11 no result from spike", {g_v, g_u}, 2'b00);
        fork
            send(1'b0, 8'h69, 3'd0);
            send(1'b1, mix(8'h69), 3'd0);
            await(3000);
        join
        check("R11 next frame data", g_d, 8'h69);
        check("R11 next frame valid", {g_v, g_r, g_u}, 3'b100);
        repeat (200) @(negedge clk);

        // R1 R2: transmit path by loopback
        loopback = 1'b1;
        @(negedge clk);
        in_data  = 8'hB4;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 ready low after accept", in_ready, 0);
        fork
            grab_red();
            await(3000);
        join
        check("R1 redundant line bits", cap_red, mix(8'hB4));
        check("R1 loopback data", g_d, 8'hB4);
        check("R1 loopback flags", {g_v, g_r, g_u}, 3'b100);
        repeat (BITCLK * 2) @(negedge clk);
        check("R2 ready back after frame", in_ready, 1);

        finish_run();
    end
endmodule